// File: doc/BRIEF.md
# Mask-Driven Interleave Address Dehasher

This block undoes the address hashing that a memory fabric applies when it spreads traffic over a power-of-two number of channels. It takes a channel-relative address and returns the address with its interleave-select bits corrected. Each corrected bit is flipped when the parity of a few higher address bits is odd. Four page-size hash enables gate those higher bits: 64K, 2M, 1G and 1T.

The bits that need correction are not fixed. The block builds a selection mask from the total channel count. It takes (count − 1) shifted up by eight places, then opens a gap of zero bits in it. The gap's position and width depend on whether the fabric interleaves at 1K or 2K granularity. Only the candidate bits 8, 9, 12, 13 and 14 that end up set in the mask are corrected. The corrections are applied from the lowest to the highest. The gap insertion is a generic combinational unit whose position and width are parameters.

A request is accepted whenever the input valid is high, and the result appears exactly one clock later. There is no backpressure. A channel count that is not 2, 4, 8 or 16 raises an error flag alongside the result.

Top module: `rv_dehasher`

## Requirements
- R1: `outValid` is high in the cycle after a cycle in which `inValid` was high, and low in the cycle after a cycle in which `inValid` was low.
- R2: While `inValid` is low, `outAddr` and `outErr` keep their last values.
- R3: With `gran2k` = 0 (1K granularity), the corrected bit set is: {8} for 2 channels, {8,9} for 4, {8,9,12} for 8, and {8,9,12,13} for 16. This follows from inserting two zero bits at position 10 of the mask (count − 1) << 8.
- R4: With `gran2k` = 1 (2K granularity), the corrected bit set is: {8} for 2 channels, {8,12} for 4, {8,12,13} for 8, and {8,12,13,14} for 16. This follows from inserting three zero bits at position 9 of the same mask.
- R5: Each selected bit is XORed with the parity of its gated sources. The gating uses `hashEn[0]`=64K, `hashEn[1]`=2M, `hashEn[2]`=1G and `hashEn[3]`=1T. The sources for each target bit are:
  - bit 8: sources 16, 21, 30, 40
  - bit 9: sources 17, 22, 31, 41
  - bit 12: sources 18, 23, 32, 42
  - bit 13: sources 19, 24, 33, 43
  - bit 14: sources 20, 25, 34, 44
- R6: Every address bit other than the selected target bits passes through unchanged. This includes candidate bits that are not set in the mask.
- R7: With `hashEn` = 0, the output address equals the input address for every valid channel count.
- R8: If `totalChan` is not one of 2, 4, 8 or 16, `outErr` is 1 and the address passes through unmodified. For a valid count, `outErr` is 0.
- R9: During reset, `outValid`, `outErr` and `outAddr` are all 0.
- R10: The gap unit, given parameters W, POS and GAP, outputs its input with GAP zero bits placed at POS. Input bits at POS and above move up by GAP; bits below POS stay in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe |
| inAddr | input | ADDR_W | Hashed address |
| totalChan | input | CNT_W | Total interleaved channel count |
| gran2k | input | 1 | 1 = 2K granularity, 0 = 1K |
| hashEn | input | 4 | Hash enables {1T,1G,2M,64K} |
| outValid | output | 1 | Result strobe, one clock after request |
| outAddr | output | ADDR_W | Dehashed address |
| outErr | output | 1 | Unsupported channel count |

## Verification
The bench builds the top with its defaults: a 48-bit address and a 5-bit count port. These widths make the 1T sources at bits 40–44 reachable. They also let the count port hold illegal values such as 0, 3, 6 and 31 next to the legal ones.

A second instance of the gap unit is built with a 12-bit width, insertion at bit 5 and a three-bit gap. Its whole 4096-value input space can then be swept exhaustively against a reference. This exercises the parameterised variant that the top does not use.

// File: rtl/dehash_pkg.sv
package dehash_pkg;
  localparam int NFIX     = 5;   // candidate target bits
  localparam int VEC_W    = 16;  // selection mask width
  localparam int MAX_CHAN = 16;
  localparam int SHIFT    = 8;

  typedef struct packed {
    logic            load;
    logic            err;
    logic [NFIX-1:0] fixEn;
  } dhStrobeT;

  // target bit of correction step k: 8,9,12,13,14
  function automatic int fixPos(int k);
    return (k < 2) ? SHIFT + k : 10 + k;
  endfunction

  function automatic logic [63:0] fixMask();
    logic [63:0] m = '0;
    for (int k = 0; k < NFIX; k++) m[fixPos(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gap_insert.sv
module gap_insert #(
  parameter int W   = 16,
  parameter int POS = 10,
  parameter int GAP = 2
) (
  input  logic [W-1:0]     din,
  output logic [W+GAP-1:0] dout
);
  // R10: GAP zero bits at POS, upper bits move up
  assign dout = {din[W-1:POS], {GAP{1'b0}}, din[POS-1:0]};
endmodule

// File: rtl/dh_ctrl.sv
module dh_ctrl import dehash_pkg::*; #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [CNT_W-1:0] totalChan,
  input  logic             gran2k,
  output dhStrobeT         ctl
);
  logic [CNT_W-1:0]   chanM1;
  logic               chanOk;
  logic [VEC_W-1:0]   baseVec;
  logic [VEC_W+1:0]   vecFine;
  logic [VEC_W+2:0]   vecCoarse;
  logic [VEC_W-1:0]   selVec;
  logic [NFIX-1:0]    fixEn;
  logic               unusedBits;

  assign chanM1  = totalChan - 1'b1;
  assign chanOk  = (totalChan >= CNT_W'(2)) && (totalChan <= CNT_W'(MAX_CHAN)) &&
                   ((totalChan & chanM1) == '0);
  assign baseVec = VEC_W'(chanM1) << SHIFT;

  gap_insert #(.W(VEC_W), .POS(10), .GAP(2)) u_gapFine   (.din(baseVec), .dout(vecFine));
  gap_insert #(.W(VEC_W), .POS(9),  .GAP(3)) u_gapCoarse (.din(baseVec), .dout(vecCoarse));

  assign selVec = gran2k ? vecCoarse[VEC_W-1:0] : vecFine[VEC_W-1:0];
  assign unusedBits = ^{vecFine[VEC_W+1:VEC_W], vecCoarse[VEC_W+2:VEC_W], selVec};

  for (genvar k = 0; k < NFIX; k++) begin : g_sel
    localparam int P = fixPos(k);
    assign fixEn[k] = chanOk & selVec[P];
  end

  always_comb begin
    ctl.load  = inValid;
    ctl.err   = ~chanOk;
    ctl.fixEn = fixEn;
  end

  // R3 / R4: bit 8 is in the mask for every legal count
  a_r3_low_bit: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.err) |-> ctl.fixEn[0]);
  // R8: an illegal count selects nothing
  a_r8_no_fix: assert property (@(posedge clk) disable iff (!rstN)
    ctl.err |-> (ctl.fixEn == '0));
endmodule

// File: rtl/dh_datapath.sv
module dh_datapath import dehash_pkg::*; #(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  dhStrobeT          ctl,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [3:0]        hashEn,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outErr
);
  localparam logic [ADDR_W-1:0] KEEP = ~ADDR_W'(fixMask());

  logic [ADDR_W-1:0] stage [NFIX+1];
  assign stage[0] = inAddr;

  // steps run low to high, each on the previous result
  for (genvar k = 0; k < NFIX; k++) begin : g_step
    localparam int P = fixPos(k);
    logic par;
    assign par = ^(hashEn & {stage[k][40+k], stage[k][30+k], stage[k][21+k], stage[k][16+k]});
    assign stage[k+1] = stage[k] ^ (ADDR_W'(ctl.fixEn[k] & par) << P);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outAddr  <= '0;
      outErr   <= 1'b0;
    end else begin
      outValid <= ctl.load;
      if (ctl.load) begin
        outAddr <= stage[NFIX];
        outErr  <= ctl.err;
      end
    end
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> outValid);
  a_r1_idle: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> !outValid);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(outAddr) && $stable(outErr)));
  a_r6_untouched: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (((outAddr ^ $past(inAddr)) & KEEP) == '0));
  a_r8_err_pass: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.err) |=> (outErr && outAddr == $past(inAddr)));
endmodule

// File: rtl/rv_dehasher.sv
module rv_dehasher import dehash_pkg::*; #(
  parameter int ADDR_W = 48,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [CNT_W-1:0]  totalChan,
  input  logic              gran2k,
  input  logic [3:0]        hashEn,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outErr
);
  dhStrobeT ctl;

  dh_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .totalChan(totalChan),
    .gran2k(gran2k), .ctl(ctl));

  dh_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inAddr(inAddr), .hashEn(hashEn),
    .outValid(outValid), .outAddr(outAddr), .outErr(outErr));
endmodule

// File: tb/sim_rv_dehasher.sv
module sim_rv_dehasher;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, gran2k = 1'b0;
  logic [AW-1:0] inAddr = '0;
  logic [4:0] totalChan = 5'd2;
  logic [3:0] hashEn = '0;
  logic outValid, outErr;
  logic [AW-1:0] outAddr;

  logic [11:0] gIn = '0;
  logic [14:0] gOut;

  int checks = 0, fails = 0;
  string curTag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  rv_dehasher u0 (.clk(clk), .rstN(rstN), .inValid(inValid), .inAddr(inAddr),
    .totalChan(totalChan), .gran2k(gran2k), .hashEn(hashEn),
    .outValid(outValid), .outAddr(outAddr), .outErr(outErr));

  gap_insert #(.W(12), .POS(5), .GAP(3)) u1 (.din(gIn), .dout(gOut));

  // ---- behavioural reference ----
  function automatic logic [AW-1:0] refModel(logic [AW-1:0] a, int ch, bit g2k,
                                             logic [3:0] en, output bit err);
    int tgt [5] = '{8, 9, 12, 13, 14};
    int src [5][4] = '{'{16,21,30,40}, '{17,22,31,41}, '{18,23,32,42},
                       '{19,24,33,43}, '{20,25,34,44}};
    longint v, m;
    int pos, gap;
    bit p;
    err = !(ch == 2 || ch == 4 || ch == 8 || ch == 16);
    if (err) return a;
    v = longint'(ch - 1) << 8;
    pos = g2k ? 9 : 10;
    gap = g2k ? 3 : 2;
    m = 0;
    for (int b = 0; b < 32; b++)
      if (v[b]) m[(b < pos) ? b : b + gap] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      if (m[tgt[k]]) begin
        p = 1'b0;
        for (int j = 0; j < 4; j++) p ^= en[j] & a[src[k][j]];
        a[tgt[k]] ^= p;
      end
    end
    return a;
  endfunction

  logic mValid;
  logic [AW-1:0] mAddr;
  logic mErr;
  always @(posedge clk or negedge rstN) begin
    bit e;
    if (!rstN) begin
      mValid = 1'b0; mAddr = '0; mErr = 1'b0;
    end else begin
      mValid = inValid;
      if (inValid) begin
        mAddr = refModel(inAddr, int'(totalChan), gran2k, hashEn, e);
        mErr  = e;
      end
    end
  end

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare against model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R1", "outValid", longint'(outValid), longint'(mValid));
      check(curTag, "outAddr", longint'(outAddr), longint'(mAddr));
      check("R8", "outErr", longint'(outErr), longint'(mErr));
    end
  end

  task automatic drive(bit v, logic [AW-1:0] a, int ch, bit g, logic [3:0] en);
    @(negedge clk);
    inValid = v; inAddr = a; totalChan = 5'(ch); gran2k = g; hashEn = en;
  endtask

  task automatic directed(string tag, logic [AW-1:0] a, int ch, bit g,
                          logic [3:0] en, logic [AW-1:0] expA, bit expE);
    curTag = tag;
    drive(1'b1, a, ch, g, en);
    drive(1'b0, a, ch, g, en);
    #1;
    check(tag, "directed addr", longint'(outAddr), longint'(expA));
    check(tag, "directed err", longint'(outErr), longint'(expE));
  endtask

  function automatic int pickChan(bit legal);
    int opts [4] = '{2, 4, 8, 16};
    int bad [6] = '{0, 1, 3, 6, 12, 31};
    return legal ? opts[$urandom_range(3)] : bad[$urandom_range(5)];
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R9: reset values
    check("R9", "outValid in reset", longint'(outValid), 0);
    check("R9", "outErr in reset", longint'(outErr), 0);
    check("R9", "outAddr in reset", longint'(outAddr), 0);
    @(negedge clk) rstN = 1'b1;

    // directed corner cases
    directed("R5", 48'h1_0000, 16, 1'b1, 4'b0001, 48'h1_0100, 1'b0);
    directed("R3", 48'h200_0000_0000, 4, 1'b0, 4'b1000, 48'h200_0000_0200, 1'b0);
    directed("R4", 48'h200_0000_0000, 4, 1'b1, 4'b1000, 48'h200_0000_0000, 1'b0);
    directed("R4", 48'h4_0000_0000, 16, 1'b1, 4'b0100, 48'h4_0000_4000, 1'b0);
    directed("R6", 48'h2_0000, 2, 1'b0, 4'b1111, 48'h2_0000, 1'b0);
    directed("R8", 48'hFFFF_FFFF_FFFF, 6, 1'b0, 4'b1111, 48'hFFFF_FFFF_FFFF, 1'b1);

    // R3: 1K granularity, random traffic with idle gaps
    curTag = "R3";
    for (int i = 0; i < 800; i++)
      drive($urandom_range(3) != 0, {$urandom, $urandom}, pickChan(1'b1), 1'b0, 4'($urandom));
    // R4: 2K granularity
    curTag = "R4";
    for (int i = 0; i < 800; i++)
      drive($urandom_range(3) != 0, {$urandom, $urandom}, pickChan(1'b1), 1'b1, 4'($urandom));
    // R7: hashing off
    curTag = "R7";
    for (int i = 0; i < 200; i++) begin
      drive(1'b1, {$urandom, $urandom}, pickChan(1'b1), 1'($urandom), 4'b0000);
      if (mValid) check("R7", "identity", longint'(outAddr), longint'(mAddr));
    end
    // R8: illegal counts mixed in
    curTag = "R8";
    for (int i = 0; i < 300; i++)
      drive(1'b1, {$urandom, $urandom}, pickChan($urandom_range(1) == 1), 1'($urandom), 4'($urandom));
    // R2: long idle stretch with changing inputs must not move outputs
    curTag = "R2";
    for (int i = 0; i < 50; i++)
      drive(1'b0, {$urandom, $urandom}, pickChan(1'b1), 1'($urandom), 4'($urandom));
    drive(1'b0, '0, 2, 1'b0, 4'b0);
    @(negedge clk);

    // R10: exhaustive sweep of the parameterised gap unit
    for (int x = 0; x < 4096; x++) begin
      gIn = 12'(x);
      #1;
      check("R10", "gap_insert", longint'(gOut),
            longint'(((x >> 5) << 8) | (x & 31)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule